// File: doc/BRIEF.md
# Vector Structure De-interleave Unit

This block turns a block of packed memory bytes into new contents for up to four 64-bit vector registers. The caller gives a structure count N from 1 to 4 and an element size of 8, 16 or 32 bits. Element k of every structure is steered into register k, so neighbouring lanes of one register come from elements that lie N elements apart in memory. A count of one is a plain copy into one to four registers. A count of two can also fill four registers, and in that case it fills two pairs in turn.

Two other placement modes read a single structure. Replicate mode copies each element of that structure into every lane of its register. Single-lane mode writes each element into one chosen lane and keeps the other lanes of the current register value, which the caller also supplies.

The result, a write-enable per register and an error flag are registered. They appear one cycle after the input is accepted. An illegal request writes nothing.

Top module: `vstruct_spread`

## Requirements
- R1: `in_ready` is always high. An input is accepted in every cycle where `in_valid` is high, and `out_valid` is high in exactly the cycle after each accepted input. After reset, `out_valid`, `out_we` and `out_err` are 0 and `out_regs` is all zero. While no input is accepted, `out_regs` holds its value.
- R2: Fill mode (`in_mode`=0) with count N = `in_cnt_m1`+1, register count R = `in_nreg_m1`+1 and L lanes per register works as follows. Register r, lane l receives memory element (r/N)·N·L + l·N + (r mod N), using integer division.
- R3: In fill mode with N=1, register r holds memory bytes 8r to 8r+7 unchanged, for one to four registers.
- R4: In fill mode with N=2 and 16-bit elements, register 0 holds elements 0,2,4,6 and register 1 holds elements 1,3,5,7. With R=4, registers 2 and 3 hold the same split of elements 8 to 15.
- R5: In fill mode with N=3 (R=3) or N=4 (R=4), lane l of register k holds element l·N+k.
- R6: `in_esz` 0, 1 and 2 select 8-, 16- and 32-bit elements, giving 8, 4 and 2 lanes. Memory byte i is bits 8i+7:8i of `in_mem`. Register r is bits 64r+63:64r of `in_cur` and `out_regs`. Elements are little-endian, and the lowest-addressed element goes to lane 0 at the low end.
- R7: In replicate mode (`in_mode`=1, R=N), every lane of register k holds element k of the first structure.
- R8: In single-lane mode (`in_mode`=2, R=N), lane `in_lane` of register k holds element k. All other lanes equal the lanes of `in_cur`.
- R9: Some requests are illegal: `in_esz`=3, `in_mode`=3, N=2 with R of 1 or 3, N=3 with R≠3, N=4 with R≠4, replicate or single-lane mode with R≠N, or a single-lane `in_lane` at or above the lane count. Such a request sets `out_err`, gives `out_we`=0, and makes `out_regs` equal `in_cur`.
- R10: `out_we[r]` is 1 only for targeted registers. In fill mode these are registers below R, and in the other modes registers below N. A register that is not targeted is output as its `in_cur` value. When `out_valid` is 0, `out_we` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Always 1 |
| in_mem | input | 256 | Packed memory bytes, byte 0 lowest |
| in_cur | input | 256 | Current register contents, register 0 lowest |
| in_cnt_m1 | input | 2 | Structure count minus one |
| in_nreg_m1 | input | 2 | Register count minus one |
| in_esz | input | 2 | Element size: 0=8, 1=16, 2=32 bits |
| in_mode | input | 2 | 0 fill, 1 replicate, 2 single lane |
| in_lane | input | 3 | Lane for single-lane mode |
| out_valid | output | 1 | Result valid |
| out_regs | output | 256 | New register values |
| out_we | output | 4 | Per-register write enable |
| out_err | output | 1 | Illegal request flag |

## Verification
Every result appears at the first rising edge after the request edge. That edge loads `out_valid`, `out_we`, `out_err` and `out_regs` together. The bench drives a request on a falling edge and computes the expected outputs from the requirement formulas. It compares them on the next falling edge, after exactly one register stage. In idle cycles it expects `out_valid`, `out_we` and `out_err` to be low and `out_regs` unchanged.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [1:0] {
    PL_FILL   = 2'd0,
    PL_REPL   = 2'd1,
    PL_LANE   = 2'd2,
    PL_BAD    = 2'd3
  } place_e;

  localparam logic [1:0] ESZ_BAD = 2'd3;
endpackage

// File: rtl/vsd_decode.sv
module vsd_decode #(
  parameter int NREG   = 4,
  parameter int LANE_W = 3
) (
  input  logic [1:0]        cnt_m1,
  input  logic [1:0]        nreg_m1,
  input  logic [1:0]        esz,
  input  logic [1:0]        mode,
  input  logic [LANE_W-1:0] lane_sel,
  output logic              legal,
  output logic [NREG-1:0]   we_mask
);
  import vsd_pkg::*;

  localparam int REG_BYTES = 1 << LANE_W;

  int  n_cnt;
  int  r_cnt;
  int  lanes;
  int  tgt;
  logic combo_ok;

  always_comb begin
    n_cnt = int'(cnt_m1) + 1;
    r_cnt = int'(nreg_m1) + 1;
    lanes = REG_BYTES >> esz;
    case (n_cnt)
      1:       combo_ok = 1'b1;
      2:       combo_ok = (r_cnt == 2) || (r_cnt == 4);
      3:       combo_ok = (r_cnt == 3);
      default: combo_ok = (r_cnt == 4);
    endcase
    legal = (esz != ESZ_BAD);
    case (place_e'(mode))
      PL_FILL: legal = legal && combo_ok;
      PL_REPL: legal = legal && (r_cnt == n_cnt);
      PL_LANE: legal = legal && (r_cnt == n_cnt) && (int'(lane_sel) < lanes);
      default: legal = 1'b0;
    endcase
    tgt = (place_e'(mode) == PL_FILL) ? r_cnt : n_cnt;
    for (int i = 0; i < NREG; i++) begin
      we_mask[i] = legal && (i < tgt);
    end
  end
endmodule

// File: rtl/vsd_route.sv
module vsd_route #(
  parameter int REG_W = 64,
  parameter int NREG  = 4
) (
  input  logic [NREG*REG_W-1:0]          mem_data,
  input  logic [NREG*REG_W-1:0]          cur_regs,
  input  logic [1:0]                     cnt_m1,
  input  logic [1:0]                     esz,
  input  logic [1:0]                     mode,
  input  logic [$clog2(REG_W/8)-1:0]     lane_sel,
  output logic [NREG*REG_W-1:0]          spread
);
  import vsd_pkg::*;

  localparam int REG_BYTES = REG_W / 8;
  localparam int BLK_BYTES = NREG * REG_BYTES;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
      always_comb begin : pick
        int n, esize, lanes, lane, ebyte, grp, kidx, elem, src;
        n     = int'(cnt_m1) + 1;
        esize = 1 << esz;
        lanes = REG_BYTES >> esz;
        lane  = b >> esz;
        ebyte = b & (esize - 1);
        grp   = r / n;
        kidx  = r % n;
        if (place_e'(mode) == PL_FILL) begin
          elem = grp * n * lanes + lane * n + kidx;
        end else begin
          elem = kidx;
        end
        src = elem * esize + ebyte;
        if ((place_e'(mode) == PL_LANE) && (lane != int'(lane_sel))) begin
          spread[r*REG_W + b*8 +: 8] = cur_regs[r*REG_W + b*8 +: 8];
        end else if (src < BLK_BYTES) begin
          spread[r*REG_W + b*8 +: 8] = mem_data[src*8 +: 8];
        end else begin
          spread[r*REG_W + b*8 +: 8] = 8'h00;
        end
      end
    end
  end
endmodule

// File: rtl/vstruct_spread.sv
module vstruct_spread #(
  parameter int REG_W = 64,
  parameter int NREG  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [NREG*REG_W-1:0]         in_mem,
  input  logic [NREG*REG_W-1:0]         in_cur,
  input  logic [1:0]                    in_cnt_m1,
  input  logic [1:0]                    in_nreg_m1,
  input  logic [1:0]                    in_esz,
  input  logic [1:0]                    in_mode,
  input  logic [$clog2(REG_W/8)-1:0]    in_lane,
  output logic                          out_valid,
  output logic [NREG*REG_W-1:0]         out_regs,
  output logic [NREG-1:0]               out_we,
  output logic                          out_err
);
  localparam int LANE_W = $clog2(REG_W / 8);
  localparam int TOT_W  = NREG * REG_W;

  logic              legal;
  logic [NREG-1:0]   we_mask;
  logic [TOT_W-1:0]  spread;
  logic [TOT_W-1:0]  merged;
  logic              accept;

  assign in_ready = 1'b1;
  assign accept   = in_valid;

  vsd_decode #(.NREG(NREG), .LANE_W(LANE_W)) dec_i (
    .cnt_m1   (in_cnt_m1),
    .nreg_m1  (in_nreg_m1),
    .esz      (in_esz),
    .mode     (in_mode),
    .lane_sel (in_lane),
    .legal    (legal),
    .we_mask  (we_mask)
  );

  vsd_route #(.REG_W(REG_W), .NREG(NREG)) route_i (
    .mem_data (in_mem),
    .cur_regs (in_cur),
    .cnt_m1   (in_cnt_m1),
    .esz      (in_esz),
    .mode     (in_mode),
    .lane_sel (in_lane),
    .spread   (spread)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_merge
    assign merged[r*REG_W +: REG_W] = we_mask[r] ? spread[r*REG_W +: REG_W]
                                                 : in_cur[r*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_we    <= '0;
      out_err   <= 1'b0;
      out_regs  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_we   <= we_mask;
        out_err  <= ~legal;
        out_regs <= merged;
      end else begin
        out_we   <= '0;
        out_err  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int REG_W = 64,
  parameter int NREG  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [NREG*REG_W-1:0]      in_mem,
  input logic [NREG*REG_W-1:0]      in_cur,
  input logic [1:0]                 in_cnt_m1,
  input logic [1:0]                 in_esz,
  input logic [1:0]                 in_mode,
  input logic [$clog2(REG_W/8)-1:0] in_lane,
  input logic                       out_valid,
  input logic [NREG*REG_W-1:0]      out_regs,
  input logic [NREG-1:0]            out_we,
  input logic                       out_err
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (rst) in_ready);

  a_r1_valid_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_idle_next: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_we == '0) && !out_err);

  a_r9_err_no_we: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_we == '0));

  a_r9_err_keeps: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_regs == $past(in_cur)));

  a_r3_plain_copy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cnt_m1 == 2'd0 && in_mode == 2'd0) |=>
      (!out_we[0] || out_regs[REG_W-1:0] == $past(in_mem[REG_W-1:0])));

  a_r7_repl_bytes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd1 && in_esz == 2'd0) |=>
      (!out_we[0] || out_regs[REG_W-1:0] == {(REG_W/8){$past(in_mem[7:0])}}));

  a_r8_lane_keep: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 2'd2 && in_esz == 2'd2 && in_lane == '0) |=>
      (!out_we[0] || out_regs[REG_W-1:REG_W/2] == $past(in_cur[REG_W-1:REG_W/2])));
endmodule

bind vstruct_spread vsd_checker #(.REG_W(REG_W), .NREG(NREG)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mem    (in_mem),
  .in_cur    (in_cur),
  .in_cnt_m1 (in_cnt_m1),
  .in_esz    (in_esz),
  .in_mode   (in_mode),
  .in_lane   (in_lane),
  .out_valid (out_valid),
  .out_regs  (out_regs),
  .out_we    (out_we),
  .out_err   (out_err)
);

// File: tb/vstruct_spread_tb.sv
`timescale 1ns/1ps
module vstruct_spread_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_mem = '0;
  logic [255:0] in_cur = '0;
  logic [1:0]   in_cnt_m1 = '0, in_nreg_m1 = '0, in_esz = '0, in_mode = '0;
  logic [2:0]   in_lane = '0;
  logic         out_valid;
  logic [255:0] out_regs;
  logic [3:0]   out_we;
  logic         out_err;

  int n_vec = 0;
  int n_bad = 0;
  logic         exp_valid = 1'b0;
  logic [255:0] exp_regs = '0;
  logic [3:0]   exp_we = '0;
  logic         exp_err = 1'b0;
  string        exp_tag = "R1";

  always #2 clk = ~clk;

  vstruct_spread dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mem(in_mem), .in_cur(in_cur), .in_cnt_m1(in_cnt_m1),
    .in_nreg_m1(in_nreg_m1), .in_esz(in_esz), .in_mode(in_mode),
    .in_lane(in_lane), .out_valid(out_valid), .out_regs(out_regs),
    .out_we(out_we), .out_err(out_err)
  );

  function automatic bit is_legal(int n, int r, int esz, int mode, int lane);
    bit ok;
    if (esz == 3 || mode == 3) return 0;
    if (mode == 0) begin
      if (n == 1) ok = 1;
      else if (n == 2) ok = (r == 2 || r == 4);
      else ok = (r == n);
      return ok;
    end
    if (r != n) return 0;
    if (mode == 2 && lane >= (8 >> esz)) return 0;
    return 1;
  endfunction

  task automatic model(input logic [255:0] mem, input logic [255:0] cur,
                       input int n, input int r, input int esz, input int mode,
                       input int lane, output logic [255:0] res,
                       output logic [3:0] we, output logic err);
    int e_b, lanes, tgt, elem;
    e_b = 1 << esz; lanes = 8 / e_b;
    res = cur; we = '0;
    err = !is_legal(n, r, esz, mode, lane);
    tgt = err ? 0 : (mode == 0 ? r : n);
    for (int i = 0; i < tgt; i++) begin
      we[i] = 1'b1;
      for (int l = 0; l < lanes; l++) begin
        if (mode == 2 && l != lane) continue;
        if (mode == 0) elem = (i / n) * n * lanes + l * n + (i % n);
        else elem = i;
        for (int q = 0; q < e_b; q++)
          res[i*64 + (l*e_b + q)*8 +: 8] = mem[(elem*e_b + q)*8 +: 8];
      end
    end
  endtask

  function automatic string pick_tag(int n, int esz, int mode, bit err);
    if (err) return "R9";
    if (mode == 1) return "R7";
    if (mode == 2) return "R8";
    if (n == 1) return "R3";
    if (n == 2 && esz == 1) return "R4";
    if (n == 2) return "R2";
    return "R5";
  endfunction

  task automatic compare();
    n_vec++;
    if (out_valid !== exp_valid) begin
      n_bad++;
      $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
    end else if (out_err !== exp_err) begin
      n_bad++;
      $display("FAIL R9 out_err actual=%0b expected=%0b", out_err, exp_err);
    end else if (out_we !== exp_we) begin
      n_bad++;
      $display("FAIL R10 out_we actual=%h expected=%h", out_we, exp_we);
    end else if (out_regs !== exp_regs) begin
      n_bad++;
      $display("FAIL %s out_regs actual=%h expected=%h", exp_tag, out_regs, exp_regs);
    end
  endtask

  task automatic drive(input logic [255:0] mem, input logic [255:0] cur,
                       input int cm1, input int rm1, input int esz,
                       input int mode, input int lane, input string tag);
    logic [255:0] res; logic [3:0] we; logic err;
    in_valid = 1'b1; in_mem = mem; in_cur = cur;
    in_cnt_m1 = 2'(cm1); in_nreg_m1 = 2'(rm1); in_esz = 2'(esz);
    in_mode = 2'(mode); in_lane = 3'(lane);
    model(mem, cur, cm1 + 1, rm1 + 1, esz, mode, lane, res, we, err);
    exp_valid = 1'b1; exp_regs = res; exp_we = we; exp_err = err;
    exp_tag = (tag == "") ? pick_tag(cm1 + 1, esz, mode, err) : tag;
  endtask

  task automatic idle();
    in_valid = 1'b0; in_mode = 2'(($urandom % 3));
    exp_valid = 1'b0; exp_we = '0; exp_err = 1'b0; exp_tag = "R1";
  endtask

  function automatic logic [255:0] ramp();
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = 8'(i);
    return v;
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic step(input logic [255:0] mem, input logic [255:0] cur,
                      input int cm1, input int rm1, input int esz,
                      input int mode, input int lane, input string tag);
    @(negedge clk); compare();
    drive(mem, cur, cm1, rm1, esz, mode, lane, tag);
  endtask

  initial begin : watchdog
    #800000;
    n_bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state is all zero, quiet outputs
    @(negedge clk); compare();
    // R6: 32-bit elements, little-endian lanes, plain copy
    drive(ramp(), '1, 0, 0, 2, 0, 0, "R6");
    step(ramp(), '1, 1, 1, 1, 0, 0, "R4");
    step(ramp(), '0, 1, 3, 1, 0, 0, "R4");
    step(ramp(), '0, 1, 3, 0, 0, 0, "R2");
    step(ramp(), '0, 2, 2, 0, 0, 0, "R5");
    step(ramp(), '0, 3, 3, 0, 0, 0, "R5");
    step(ramp(), '0, 0, 3, 0, 0, 0, "R3");
    step(ramp(), rnd256(), 3, 3, 1, 1, 0, "R7");
    step(ramp(), rnd256(), 2, 2, 0, 2, 7, "R8");
    step(ramp(), rnd256(), 1, 1, 2, 2, 1, "R8");
    step(ramp(), rnd256(), 0, 0, 2, 2, 2, "R9");
    step(ramp(), rnd256(), 2, 3, 0, 0, 0, "R9");
    step(ramp(), rnd256(), 1, 2, 0, 0, 0, "R9");
    step(ramp(), rnd256(), 0, 1, 0, 1, 0, "R10");
    step(ramp(), rnd256(), 0, 0, 3, 0, 0, "R9");
    @(negedge clk); compare(); idle();
    @(negedge clk); compare(); idle();
    for (int t = 0; t < 3000; t++) begin
      int cm1, rm1, esz, mode, lane;
      @(negedge clk); compare();
      if ($urandom % 5 == 0) begin
        idle();
      end else begin
        cm1 = $urandom % 4; rm1 = $urandom % 4; esz = $urandom % 4;
        mode = $urandom % 4; lane = $urandom % 8;
        if ($urandom % 4 != 0) begin
          esz = $urandom % 3; mode = $urandom % 3;
          if (mode != 0) rm1 = cm1;
          else if (cm1 == 1) rm1 = ($urandom % 2) ? 1 : 3;
          else if (cm1 > 1) rm1 = cm1;
          if (mode == 2) lane = $urandom % (8 >> esz);
        end
        drive(rnd256(), rnd256(), cm1, rm1, esz, mode, lane, "");
      end
    end
    @(negedge clk); compare(); idle();
    @(negedge clk); compare();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule